// File: doc/BRIEF.md
# Grayscale Display Period Sequencer

This block times the display periods of a multi-channel PWM LED array. A grayscale counter advances on every grayscale clock edge, and one display period covers `2**CNT_W` clocks. The block decides when the counter restarts, when all channels are blanked, and when newly written grayscale data is committed to the working latch. It then compares each channel's committed value against the counter to drive that channel's on/off output in conventional (non-spread) PWM.

Three mode inputs change the behaviour. The repeat input makes periods run back to back. The timing-reset input lets a grayscale write restart the period. The deferred-refresh input holds new data until a full period after the write. The block also issues three strobes. The period-end strobe marks the counter wrapping. The commit strobe marks a latch copy. The fault-capture strobe marks the cycle at which open/short LED status should be sampled.

A grayscale write is presented as a one-cycle `lat_i` pulse, synchronous to the grayscale clock, with the new channel values on `gs_data_i`.

Top module: `gs_period_seq`

## Requirements
- R1: After reset, `cnt_o` is 0, `force_off_o` is 1, `pwm_o` is all zero and no strobe is high. The committed latch holds zeros. This state persists on a running clock until the first `lat_i`.
- R2: While a period runs, `cnt_o` rises by one per clock through 1 .. `2**CNT_W-1` and then wraps to 0. A period is `2**CNT_W` clocks long, and `force_off_o` is 1 whenever `cnt_o` is 0.
- R3: Channel i takes its value from `gs_data_i[i*CNT_W +: CNT_W]`. Its output is 1 exactly when `force_off_o` is 0 and `cnt_o` is less than or equal to its committed value, so a value of 0 never lights.
- R4: `period_end_o` is high for exactly one cycle, in the cycle whose `cnt_o` is 0 right after the counter held `2**CNT_W-1`.
- R5: With `rpt_en_i` = 1 the clock after a wrap brings `cnt_o` to 1. With `rpt_en_i` = 0 the wrap stops the sequencer: `cnt_o` holds 0 and `force_off_o` holds 1 until the next `lat_i`.
- R6: A `lat_i` with `tmg_rst_en_i` = 1 makes the next cycle show `cnt_o` = 0 and `force_off_o` = 1. The following clock brings `cnt_o` to 1.
- R7: A `lat_i` with `tmg_rst_en_i` = 0 while a period runs leaves the counter stepping by one as if no write occurred.
- R8: A `lat_i` while stopped (after reset or after a single period) starts a new period whatever `tmg_rst_en_i` is.
- R9: A `lat_i` with `defer_en_i` = 0 commits `gs_data_i` at that edge. `commit_o` is high in the next cycle, and `pwm_o` uses the new values from that cycle.
- R10: A `lat_i` with `defer_en_i` = 1 stores `gs_data_i` but commits it only on the `2**CNT_W`-th clock after the write, with `commit_o` high in the cycle after that clock. Until then the old values drive `pwm_o`.
- R11: A second deferred `lat_i` before the commit replaces the stored data and restarts the `2**CNT_W`-clock wait from itself.
- R12: `fault_cap_o` is high for one cycle per period, in the cycle where `cnt_o` equals `CAP_AT`.
- R13: An immediate `lat_i` while a deferred commit is pending commits its own data at once and cancels the pending commit, so no later `commit_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Grayscale clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lat_i | input | 1 | One-cycle grayscale write event |
| rpt_en_i | input | 1 | Repeat periods continuously |
| tmg_rst_en_i | input | 1 | Write restarts the period |
| defer_en_i | input | 1 | Defer commit by one full period |
| gs_data_i | input | NUM_CH*CNT_W | New channel values, channel 0 in the low bits |
| cnt_o | output | CNT_W | Grayscale counter |
| force_off_o | output | 1 | All channels blanked |
| period_end_o | output | 1 | Counter wrap strobe |
| commit_o | output | 1 | Latch copy strobe |
| fault_cap_o | output | 1 | Fault-status capture strobe |
| pwm_o | output | NUM_CH | Per-channel PWM outputs |

## Verification
The bench sweeps every channel value of a narrow configuration and checks each cycle's outputs against an arithmetic model of the requirements. Around that sweep, directed cases target the mode interactions. A design that counted the deferred wait from the period boundary instead of from the write would commit early when the write does not restart the counter. A design that stayed running after a single period would light channels in the second period. If a write without timing reset disturbed the counter, the count would jump. Off-by-one compare errors show up as lit channels at value 0 or dark channels at the maximum value. Two further cases check that a second deferred write and an immediate write during a pending deferral change the commit time and the data as required.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_e;
endpackage

// File: rtl/gsp_period_ctr.sv
module gsp_period_ctr
  import gsp_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CAP_AT = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lat_i,
  input  logic             tmg_rst_en_i,
  input  logic             rpt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             period_end_o,
  output logic             fault_cap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CAP_PRE = CNT_W'(CAP_AT - 1);

  run_e             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_q, fcap_q;
  logic             restart, wrap, running;

  assign running = (run_q == RUN_ACTIVE);
  assign restart = lat_i && (tmg_rst_en_i || !running);
  assign wrap    = running && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= RUN_IDLE;
      cnt_q  <= '0;
      end_q  <= 1'b0;
      fcap_q <= 1'b0;
    end else begin
      end_q  <= !restart && wrap;
      fcap_q <= !restart && running && (cnt_q == CAP_PRE);
      if (restart) begin
        run_q <= RUN_ACTIVE;
        cnt_q <= '0;
      end else if (running) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (wrap && !rpt_en_i) run_q <= RUN_IDLE;
      end
    end
  end

  assign cnt_o        = cnt_q;
  assign run_o        = running;
  assign period_end_o = end_q;
  assign fault_cap_o  = fcap_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && !lat_i && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running && !lat_i |=> !running && cnt_q == '0); // R5
endmodule

// File: rtl/gsp_refresh_ctl.sv
module gsp_refresh_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lat_i,
  input  logic defer_en_i,
  output logic copy_direct_o,
  output logic copy_stage_o,
  output logic commit_o
);
  localparam logic [CNT_W-1:0] WAIT_MAX = '1;

  logic             pend_q, commit_q;
  logic [CNT_W-1:0] wait_q;
  logic             due;

  assign due           = pend_q && (wait_q == WAIT_MAX);
  assign copy_direct_o = lat_i && !defer_en_i;
  assign copy_stage_o  = due && !copy_direct_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      wait_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= copy_direct_o || copy_stage_o;
      if (lat_i && defer_en_i) begin
        pend_q <= 1'b1;
        wait_q <= '0;
      end else if (lat_i || due) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        wait_q <= wait_q + CNT_W'(1);
      end
    end
  end

  assign commit_o = commit_q;

  AST_DEFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && lat_i && defer_en_i |=> !commit_q); // R10
  AST_DIRECT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_i && !defer_en_i |=> commit_q && !pend_q); // R9
endmodule

// File: rtl/gsp_gs_bank.sv
module gsp_gs_bank #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lat_i,
  input  logic                    copy_direct_i,
  input  logic                    copy_stage_i,
  input  logic [NUM_CH*CNT_W-1:0] gs_data_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    blank_i,
  output logic [NUM_CH-1:0]       pwm_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] stage_q, act_q;
    logic [CNT_W-1:0] wr_val;
    assign wr_val = gs_data_i[ch*CNT_W +: CNT_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_q   <= '0;
      end else begin
        if (lat_i) stage_q <= wr_val;
        if (copy_direct_i)     act_q <= wr_val;
        else if (copy_stage_i) act_q <= stage_q;
      end
    end

    assign pwm_o[ch] = !blank_i && (cnt_i <= act_q);
  end
endmodule

// File: rtl/gs_period_seq.sv
module gs_period_seq #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 48,
  parameter int unsigned CAP_AT = 33
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lat_i,
  input  logic                    rpt_en_i,
  input  logic                    tmg_rst_en_i,
  input  logic                    defer_en_i,
  input  logic [NUM_CH*CNT_W-1:0] gs_data_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    force_off_o,
  output logic                    period_end_o,
  output logic                    commit_o,
  output logic                    fault_cap_o,
  output logic [NUM_CH-1:0]       pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CAP_VAL = CNT_W'(CAP_AT);

  logic run, copy_direct, copy_stage;

  gsp_period_ctr #(.CNT_W(CNT_W), .CAP_AT(CAP_AT)) i_ctr (
    .clk_i, .rst_ni, .lat_i, .tmg_rst_en_i, .rpt_en_i,
    .cnt_o, .run_o(run), .period_end_o, .fault_cap_o
  );

  gsp_refresh_ctl #(.CNT_W(CNT_W)) i_refresh (
    .clk_i, .rst_ni, .lat_i, .defer_en_i,
    .copy_direct_o(copy_direct), .copy_stage_o(copy_stage), .commit_o
  );

  assign force_off_o = !run || (cnt_o == '0);

  gsp_gs_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_bank (
    .clk_i, .rst_ni, .lat_i,
    .copy_direct_i(copy_direct), .copy_stage_i(copy_stage),
    .gs_data_i, .cnt_i(cnt_o), .blank_i(force_off_o), .pwm_o
  );

  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_o |-> pwm_o == '0); // R3
  AST_END_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> cnt_o == '0 && $past(cnt_o) == CNT_MAX); // R4
  AST_SINGLE_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_off_o && cnt_o == CNT_MAX && !rpt_en_i && !lat_i |=> force_off_o && period_end_o); // R5
  AST_TMG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_i && tmg_rst_en_i |=> cnt_o == '0 && force_off_o); // R6
  AST_FCAP_AT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_cap_o |-> cnt_o == CAP_VAL && !force_off_o); // R12
endmodule

// File: tb/test_gs_period_seq.sv
module test_gs_period_seq;
  localparam int W = 5;
  localparam int NCH = 4;
  localparam int CAP = 3;
  localparam int P = 1 << W;
  localparam int MAXV = P - 1;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lat = 1'b0, rpt = 1'b1, tmg = 1'b0, dfr = 1'b0;
  logic [NCH*W-1:0] gs = '0;
  logic [W-1:0] cnt_o;
  logic force_off_o, period_end_o, commit_o, fault_cap_o;
  logic [NCH-1:0] pwm_o;

  int n_chk = 0, n_fail = 0;

  int m_cnt, m_run, m_end, m_fcap, m_commit, m_pend, m_wait;
  int m_act[NCH];
  int m_stg[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  gs_period_seq #(.CNT_W(W), .NUM_CH(NCH), .CAP_AT(CAP)) i_gs_period_seq (
    .clk_i(clk), .rst_ni(rst_n), .lat_i(lat), .rpt_en_i(rpt), .tmg_rst_en_i(tmg),
    .defer_en_i(dfr), .gs_data_i(gs), .cnt_o, .force_off_o, .period_end_o,
    .commit_o, .fault_cap_o, .pwm_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NCH*W-1:0] pack(input int a, input int b, input int c, input int d);
    logic [NCH*W-1:0] v;
    v[0*W +: W] = W'(a);
    v[1*W +: W] = W'(b);
    v[2*W +: W] = W'(c);
    v[3*W +: W] = W'(d);
    return v;
  endfunction

  task automatic cmp_all();
    int ep;
    int off;
    off = (m_run == 0 || m_cnt == 0);
    ep = 0;
    for (int i = 0; i < NCH; i++)
      if (!off && m_cnt <= m_act[i]) ep |= (1 << i);
    chk(cnt_o == W'(m_cnt), "R2 cnt", int'(cnt_o), m_cnt);
    chk(force_off_o == off[0], "R2 force_off", int'(force_off_o), off);
    chk(int'(pwm_o) == ep, "R3 pwm", int'(pwm_o), ep);
    chk(period_end_o == m_end[0], "R4 period_end", int'(period_end_o), m_end);
    chk(commit_o == m_commit[0], "R9 commit", int'(commit_o), m_commit);
    chk(fault_cap_o == m_fcap[0], "R12 fault_cap", int'(fault_cap_o), m_fcap);
  endtask

  task automatic tick();
    int restart, wrap, cdir, due;
    restart = lat && (tmg || m_run == 0);
    wrap = (m_run != 0) && (m_cnt == MAXV);
    cdir = lat && !dfr;
    due = m_pend && (m_wait == MAXV);
    @(posedge clk);
    @(negedge clk);
    m_end = !restart && wrap;
    m_fcap = !restart && m_run != 0 && m_cnt == CAP - 1;
    m_commit = cdir || due;
    if (restart) begin
      m_cnt = 0; m_run = 1;
    end else if (m_run != 0) begin
      m_cnt = (m_cnt + 1) % P;
      if (wrap && !rpt) m_run = 0;
    end
    for (int i = 0; i < NCH; i++) begin
      if (cdir) m_act[i] = int'(gs[i*W +: W]);
      else if (due) m_act[i] = m_stg[i];
      if (lat) m_stg[i] = int'(gs[i*W +: W]);
    end
    if (lat && dfr) begin
      m_pend = 1; m_wait = 0;
    end else if (lat || due) m_pend = 0;
    else if (m_pend != 0) m_wait = m_wait + 1;
    cmp_all();
  endtask

  task automatic write(input logic [NCH*W-1:0] d, input logic t, input logic df);
    lat = 1'b1; gs = d; tmg = t; dfr = df;
    tick();
    lat = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    m_cnt = 0; m_run = 0; m_end = 0; m_fcap = 0; m_commit = 0; m_pend = 0; m_wait = 0;
    for (int i = 0; i < NCH; i++) begin m_act[i] = 0; m_stg[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_all();

    // R1: idle with clock running
    for (int k = 0; k < 10; k++) tick();
    chk(cnt_o == 0 && force_off_o && pwm_o == 0, "R1 idle", int'(cnt_o), 0);

    // R9, R6, R8
    rpt = 1'b1;
    write(pack(0, 1, 17, 31), 1'b1, 1'b0);
    chk(commit_o == 1'b1, "R9 direct commit", int'(commit_o), 1);
    chk(cnt_o == 0 && force_off_o, "R8 start", int'(cnt_o), 0);
    repeat (3) tick();
    chk(cnt_o == 3, "R2 step", int'(cnt_o), 3);
    chk(pwm_o == 4'b1100, "R3 compare", int'(pwm_o), 12);
    n = 0;
    while (!period_end_o && n < 40) begin tick(); n++; end
    chk(period_end_o && cnt_o == 0, "R4 wrap", int'(cnt_o), 0);
    tick();
    chk(cnt_o == 1 && pwm_o == 4'b1110, "R5 repeat", int'(cnt_o), 1);

    // R7: write without timing reset keeps counting
    repeat (5) tick();
    write(pack(31, 31, 31, 31), 1'b0, 1'b0);
    chk(cnt_o == 7, "R7 no disturb", int'(cnt_o), 7);
    chk(pwm_o == 4'b1111, "R9 new data", int'(pwm_o), 15);

    // R6
    repeat (4) tick();
    write(pack(31, 31, 31, 31), 1'b1, 1'b0);
    chk(cnt_o == 0 && force_off_o, "R6 restart", int'(cnt_o), 0);
    tick();
    chk(cnt_o == 1, "R6 resume", int'(cnt_o), 1);

    // R5: single period stops
    rpt = 1'b0;
    n = 0;
    while (!period_end_o && n < 40) begin tick(); n++; end
    repeat (40) tick();
    chk(force_off_o && cnt_o == 0 && pwm_o == 0, "R5 single stop", int'(cnt_o), 0);

    // R8: write while stopped, no timing reset
    write(pack(2, 2, 2, 2), 1'b0, 1'b0);
    chk(cnt_o == 0, "R8 idle start", int'(cnt_o), 0);
    tick();
    chk(cnt_o == 1 && !force_off_o, "R8 running", int'(cnt_o), 1);
    rpt = 1'b1;

    // R10: deferred commit
    write(pack(31, 31, 31, 31), 1'b1, 1'b0);
    write(pack(0, 0, 0, 0), 1'b1, 1'b1);
    chk(commit_o == 1'b0, "R10 no early commit", int'(commit_o), 0);
    n = 0;
    while (!commit_o && n < 100) begin
      tick(); n++;
      if (n == 5) chk(pwm_o == 4'b1111, "R10 old data", int'(pwm_o), 15);
    end
    chk(n == P, "R10 delay", n, P);
    tick();
    chk(pwm_o == 0, "R10 new data", int'(pwm_o), 0);

    // R11: second deferred write restarts wait
    write(pack(5, 5, 5, 5), 1'b1, 1'b1);
    repeat (10) tick();
    write(pack(9, 9, 9, 9), 1'b0, 1'b1);
    n = 0;
    while (!commit_o && n < 100) begin tick(); n++; end
    chk(n == P, "R11 restart wait", n, P);
    n = 0;
    while (cnt_o != 7 && n < 40) begin tick(); n++; end
    chk(pwm_o == 4'b1111, "R11 newest data", int'(pwm_o), 15);

    // R13: immediate write cancels pending deferral
    write(pack(3, 3, 3, 3), 1'b1, 1'b1);
    repeat (4) tick();
    write(pack(20, 20, 20, 20), 1'b0, 1'b0);
    chk(commit_o == 1'b1, "R13 immediate", int'(commit_o), 1);
    n = 0;
    for (int k = 0; k < 2 * P; k++) begin tick(); if (commit_o) n++; end
    chk(n == 0, "R13 cancelled", n, 0);

    // R12
    write(pack(20, 20, 20, 20), 1'b1, 1'b0);
    repeat (CAP) tick();
    chk(fault_cap_o == 1'b1 && cnt_o == CAP, "R12 capture", int'(cnt_o), CAP);
    tick();
    chk(fault_cap_o == 1'b0, "R12 one cycle", int'(fault_cap_o), 0);

    // sweep of all channel values, both refresh modes
    for (int k = 0; k < 8; k++) begin
      write(pack((k*4) % P, (k*4+1) % P, (k*4+2) % P, (k*4+3) % P), 1'b1, k[0]);
      repeat (2 * P + 3) tick();
    end

    summary();
    $finish;
  end
endmodule